// File: doc/BRIEF.md
# Four-Phase Handshake Word Buffer

This block is a one-word holding stage between a producer and a consumer that both speak a return-to-zero request/acknowledge protocol. The producer puts a word on its data bus and raises its request. When the stage is empty it registers the word and raises its acknowledge. The producer then withdraws its request, and the stage lowers its acknowledge after seeing that.

Once it holds a word, the stage presents the word to the consumer and raises its own request. The request stays up until the consumer acknowledges. The stage then lowers its request and waits for the consumer to lower its acknowledge, which ends the delivery and empties the slot. Because there is only one slot, acceptances and deliveries strictly alternate. A new word may be accepted on the same clock edge that ends the previous delivery. Everything is synchronous to one clock with an active-low synchronous reset.

Top module: `hs_word_buffer`

## Requirements
- R1: While reset is low, `snd_ack` and `rcv_req` are driven low and the slot is emptied. After reset, `rcv_req` stays low until a word has been accepted.
- R2: When `snd_req` is sampled high on an edge while the slot is free, the word on `snd_data` is registered on that edge and `snd_ack` is high after it. `snd_ack` is never high earlier.
- R3: `snd_ack` stays high while `snd_req` is sampled high. It drops on the edge where `snd_req` is first sampled low.
- R4: The edge after a word is accepted, `rcv_req` rises, provided `rcv_ack` is low. `rcv_req` stays high until `rcv_ack` is sampled high, and drops on that edge.
- R5: `rcv_req` never rises on an edge where `rcv_ack` is sampled high. A word that arrives while `rcv_ack` is high waits, and `rcv_req` rises on the edge where `rcv_ack` is first sampled low.
- R6: While `rcv_req` is high, `rcv_data` equals the word registered at the most recent acceptance and does not change, even if `snd_data` changes after the acceptance.
- R7: No second word is accepted before the stored word has been delivered. A held `snd_req` gets no `snd_ack` while the slot is occupied.
- R8: Each accepted word is requested exactly once. After a delivery completes, `rcv_req` stays low until another word is accepted.
- R9: A waiting word is accepted on the exact edge where `rcv_ack` is first sampled low after the stage dropped `rcv_req`, and not on any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| snd_req | input | 1 | Producer request |
| snd_data | input | 32 | Producer word |
| snd_ack | output | 1 | Acknowledge to producer |
| rcv_req | output | 1 | Request to consumer |
| rcv_data | output | 32 | Stored word presented to consumer |
| rcv_ack | input | 1 | Consumer acknowledge |

## Verification
The protocol assertions assume that both neighbours obey the return-to-zero rules. The producer keeps `snd_req` and `snd_data` steady until it sees `snd_ack`, and it does not raise a new request until `snd_ack` has fallen. The consumer raises `rcv_ack` only in answer to `rcv_req`, apart from a level it deliberately holds from before the request. The stimulus drives each side as such a neighbour. The only exception is a consumer acknowledge that is already high when a word arrives; this case is used on purpose to exercise R5. Every pattern keeps the input request level until the acknowledge shows, and releases it only afterwards.

// File: rtl/hsbuf_pkg.sv
// Shared state encodings for the handshake word buffer.
package hsbuf_pkg;
    // Producer-side handshake phase.
    typedef enum logic {
        IN_IDLE  = 1'b0,
        IN_ACKED = 1'b1
    } in_st_e;

    // Consumer-side handshake phase.
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_REQ  = 2'd1,
        OUT_RTZ  = 2'd2
    } out_st_e;
endpackage

// File: rtl/hsbuf_in_port.sv
// Producer-side handshake controller.
// Raises the acknowledge one edge after an accepted request. Holds it until
// the request is seen low.
// Assumes: the producer holds its request until it sees the acknowledge.
module hsbuf_in_port
    import hsbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snd_req,
    input  logic slot_free,
    output logic snd_ack,
    output logic capture
);
    in_st_e st_q;

    // Accept only from idle, with a live request and room in the slot.
    always_comb capture = (st_q == IN_IDLE) && snd_req && slot_free;

    // Phase register for the producer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= IN_IDLE;
        end else begin
            case (st_q)
                IN_IDLE:  if (capture)  st_q <= IN_ACKED;
                IN_ACKED: if (!snd_req) st_q <= IN_IDLE;
                default:  st_q <= IN_IDLE;
            endcase
        end
    end

    always_comb snd_ack = (st_q == IN_ACKED);

    // R2: the acknowledge rises only after a request was sampled.
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_ack) |-> $past(snd_req));
    // R3: the acknowledge holds while the request is still high.
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ack && snd_req) |=> snd_ack);
    // R3: the acknowledge returns to zero after the request drops.
    p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ack && !snd_req) |=> !snd_ack);
endmodule

// File: rtl/hsbuf_slot.sv
// One-word storage with an occupancy flag.
// The slot counts as free when it is empty, or when the consumer handshake
// finishes on this edge.
// Assumes: capture is asserted only while slot_free is high.
module hsbuf_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    input  logic              release_i,
    output logic              full,
    output logic              slot_free,
    output logic [DATA_W-1:0] dout
);
    logic              full_q;
    logic [DATA_W-1:0] word_q;

    // Occupancy: a capture wins over a release on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         full_q <= 1'b0;
        else if (capture)   full_q <= 1'b1;
        else if (release_i) full_q <= 1'b0;
    end

    // Data register: loaded only by an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= din;
    end

    always_comb begin
        full      = full_q;
        slot_free = !full_q || release_i;
        dout      = word_q;
    end

    // R7: a capture never lands on an occupied slot that is not being released.
    p_capture_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!full_q || release_i));
endmodule

// File: rtl/hsbuf_out_port.sv
// Consumer-side handshake controller.
// Raises the request while a word is held and the consumer acknowledge is
// low. Drops it when the acknowledge arrives, then waits for the acknowledge
// to return to zero.
// Assumes: the consumer keeps its acknowledge high until the request drops.
module hsbuf_out_port
    import hsbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic rcv_ack,
    output logic rcv_req,
    output logic release_o
);
    out_st_e st_q;

    // Phase register for the consumer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= OUT_IDLE;
        end else begin
            case (st_q)
                OUT_IDLE: if (full && !rcv_ack) st_q <= OUT_REQ;
                OUT_REQ:  if (rcv_ack)          st_q <= OUT_RTZ;
                OUT_RTZ:  if (!rcv_ack)         st_q <= OUT_IDLE;
                default:  st_q <= OUT_IDLE;
            endcase
        end
    end

    // Outputs decoded from the phase.
    always_comb begin
        rcv_req   = (st_q == OUT_REQ);
        release_o = (st_q == OUT_RTZ) && !rcv_ack;
    end

    // R4: the request holds until it is acknowledged.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && !rcv_ack) |=> rcv_req);
    // R4: the request drops once the acknowledge is seen.
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && rcv_ack) |=> !rcv_req);
    // R5: no new request while the previous acknowledge is still high.
    p_req_after_rtz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rcv_req) |-> !$past(rcv_ack));
endmodule

// File: rtl/hs_word_buffer.sv
// Single-word buffer with four-phase handshakes on both sides.
// Connects the producer controller, the storage slot and the consumer
// controller. Also holds checker registers for the end-to-end assertions.
// Assumes: both neighbours follow the return-to-zero protocol.
module hs_word_buffer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_req,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_ack,
    output logic              rcv_req,
    output logic [DATA_W-1:0] rcv_data,
    input  logic              rcv_ack
);
    logic capture;
    logic slot_free;
    logic full;
    logic release_w;

    hsbuf_in_port u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_req   (snd_req),
        .slot_free (slot_free),
        .snd_ack   (snd_ack),
        .capture   (capture)
    );

    hsbuf_slot #(.DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .din       (snd_data),
        .release_i (release_w),
        .full      (full),
        .slot_free (slot_free),
        .dout      (rcv_data)
    );

    hsbuf_out_port u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .full      (full),
        .rcv_ack   (rcv_ack),
        .rcv_req   (rcv_req),
        .release_o (release_w)
    );

    // Checker bookkeeping: this state is seen only at the ports.
    logic              ack_d, rack_d, pend_q;
    logic [DATA_W-1:0] data_d, seen_q;

    // Tracks one outstanding accepted word and its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d  <= 1'b0;
            rack_d <= 1'b0;
            pend_q <= 1'b0;
            data_d <= '0;
            seen_q <= '0;
        end else begin
            ack_d  <= snd_ack;
            rack_d <= rcv_ack;
            data_d <= snd_data;
            if (snd_ack && !ack_d) begin
                pend_q <= 1'b1;
                seen_q <= data_d;
            end else if (rcv_req && rcv_ack && !rack_d) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R7: no acceptance while an earlier word is still undelivered.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ack && !ack_d) |-> !pend_q);
    // R8: every delivery consumes an outstanding accepted word.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && rcv_ack && !rack_d) |-> pend_q);
    // R6: the presented word is the one the producer handed over.
    p_data_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_req |-> (rcv_data == seen_q));
    // R6: the output word is stable while requested.
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && $past(rcv_req)) |-> $stable(rcv_data));
    // R1: both handshake outputs are low on the first edge after reset.
    p_reset_low_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!snd_ack && !rcv_req));
endmodule

// File: tb/sim_hs_word_buffer.sv
module sim_hs_word_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snd_req = 1'b0;
    logic [31:0] snd_data = '0;
    logic        rcv_ack = 1'b0;
    logic        snd_ack, rcv_req;
    logic [31:0] rcv_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hs_word_buffer u0 (
        .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_data(snd_data),
        .snd_ack(snd_ack), .rcv_req(rcv_req), .rcv_data(rcv_data),
        .rcv_ack(rcv_ack)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One complete transfer that starts and ends with both sides idle.
    task automatic xfer(input logic [31:0] d, input int dly, input int hold);
        snd_data = d; snd_req = 1'b1;
        check(snd_ack == 1'b0, "R2 early", {31'd0, snd_ack}, 0);
        tick();
        check(snd_ack == 1'b1, "R2 ack", {31'd0, snd_ack}, 1);
        check(rcv_req == 1'b0, "R4 not yet", {31'd0, rcv_req}, 0);
        snd_req = 1'b0; snd_data = ~d;
        tick();
        check(snd_ack == 1'b0, "R3 drop", {31'd0, snd_ack}, 0);
        check(rcv_req == 1'b1, "R4 rise", {31'd0, rcv_req}, 1);
        check(rcv_data == d, "R6 data", rcv_data, d);
        for (int k = 0; k < dly; k++) begin
            snd_data = d ^ (32'h1 << k);
            tick();
            check(rcv_req == 1'b1, "R4 hold", {31'd0, rcv_req}, 1);
            check(rcv_data == d, "R6 stable", rcv_data, d);
        end
        rcv_ack = 1'b1;
        tick();
        check(rcv_req == 1'b0, "R4 drop", {31'd0, rcv_req}, 0);
        for (int k = 0; k < hold; k++) begin
            tick();
            check(rcv_req == 1'b0, "R5 ack high", {31'd0, rcv_req}, 0);
        end
        rcv_ack = 1'b0;
        tick();
        check(rcv_req == 1'b0, "R8 once", {31'd0, rcv_req}, 0);
        tick();
        check(rcv_req == 1'b0, "R8 once", {31'd0, rcv_req}, 0);
        check(snd_ack == 1'b0, "R8 idle ack", {31'd0, snd_ack}, 0);
    endtask

    initial begin
        tick(); tick();
        check(snd_ack == 1'b0, "R1 ack", {31'd0, snd_ack}, 0);
        check(rcv_req == 1'b0, "R1 req", {31'd0, rcv_req}, 0);
        rst_n = 1'b1;
        rcv_ack = 1'b1;   // stray consumer level: ignored while empty
        tick(); tick(); tick();
        check(rcv_req == 1'b0, "R1 empty", {31'd0, rcv_req}, 0);
        rcv_ack = 1'b0;
        tick(); tick();
        check(rcv_req == 1'b0, "R1 empty", {31'd0, rcv_req}, 0);

        // Sweep: walking ones, then scrambled words; delays cycle through.
        for (int i = 0; i < 44; i++) begin
            logic [31:0] w;
            if (i < 32)       w = 32'h1 << i;
            else if (i == 32) w = 32'h0;
            else if (i == 33) w = 32'hFFFF_FFFF;
            else              w = (i * 32'h9E37_79B9) ^ 32'hA5A5_0F0F;
            xfer(w, i % 4, (i / 4) % 3);
        end

        // R7 / R9: second word waits and is taken on the return-to-zero edge.
        snd_data = 32'hCAFE_0001; snd_req = 1'b1;
        tick();
        check(snd_ack == 1'b1, "R2 ack A", {31'd0, snd_ack}, 1);
        snd_req = 1'b0;
        tick();
        check(rcv_data == 32'hCAFE_0001, "R6 A", rcv_data, 32'hCAFE_0001);
        snd_data = 32'hBEEF_0002; snd_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check(snd_ack == 1'b0, "R7 held off", {31'd0, snd_ack}, 0);
            check(rcv_data == 32'hCAFE_0001, "R7 kept A", rcv_data, 32'hCAFE_0001);
        end
        rcv_ack = 1'b1;
        tick();
        check(snd_ack == 1'b0, "R9 not before", {31'd0, snd_ack}, 0);
        tick();
        check(snd_ack == 1'b0, "R9 not before", {31'd0, snd_ack}, 0);
        rcv_ack = 1'b0;
        tick();
        check(snd_ack == 1'b1, "R9 same edge", {31'd0, snd_ack}, 1);
        check(rcv_req == 1'b0, "R9 req low", {31'd0, rcv_req}, 0);
        snd_req = 1'b0; snd_data = 32'h0;
        tick();
        check(rcv_req == 1'b1, "R4 rise B", {31'd0, rcv_req}, 1);
        check(rcv_data == 32'hBEEF_0002, "R6 B", rcv_data, 32'hBEEF_0002);
        rcv_ack = 1'b1;
        tick();
        rcv_ack = 1'b0;
        tick(); tick();
        check(rcv_req == 1'b0, "R8 after B", {31'd0, rcv_req}, 0);

        // R5: consumer acknowledge already high when a word arrives.
        rcv_ack = 1'b1;
        snd_data = 32'h1234_5678; snd_req = 1'b1;
        tick();
        snd_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            check(rcv_req == 1'b0, "R5 wait", {31'd0, rcv_req}, 0);
        end
        rcv_ack = 1'b0;
        tick();
        check(rcv_req == 1'b1, "R5 rise", {31'd0, rcv_req}, 1);
        check(rcv_data == 32'h1234_5678, "R6 C", rcv_data, 32'h1234_5678);
        rcv_ack = 1'b1;
        tick();
        rcv_ack = 1'b0;
        tick(); tick();

        // R1: reset while holding a word empties the slot.
        snd_data = 32'h0F0F_AAAA; snd_req = 1'b1;
        tick();
        snd_req = 1'b0;
        rst_n = 1'b0;
        tick();
        check(snd_ack == 1'b0, "R1 mid ack", {31'd0, snd_ack}, 0);
        check(rcv_req == 1'b0, "R1 mid req", {31'd0, rcv_req}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check(rcv_req == 1'b0, "R1 flushed", {31'd0, rcv_req}, 0);
        end
        xfer(32'h5555_AAAA, 1, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule